// File: doc/BRIEF.md
# Open-Drain Bus Driver with Multi-Master Arbitration Check

This block sits between a master bit sequencer and the two open-drain pads of a two-wire serial bus (data and clock). The sequencer gives the level it wants on each line. The block turns each level into an active-low drive enable. The pad output value is tied low, so a 0 is sent by turning the driver on and a 1 by letting the line float high.

When several masters share the bus, one master may release the data line while another pulls it low. The block synchronizes both sensed lines. Whenever it is releasing data and the sensed clock is high, it compares the sensed data with the released (high) level. A low reading means another master has won. The block then releases both lines in the same cycle and records the loss with the phase the sequencer reported: address or data.

A loss in the data phase raises a retransmit request. A loss in the address phase raises a hint that the slave receive path should keep listening, because this device may be the one being addressed. The lines stay released until the sequencer pulses a new-transfer start. The loss status stays set until software pulses a clear.

Top module: `od_arb_driver`

## Requirements
- R1: Both pad output values (`sda_out_o`, `scl_out_o`) are 0 in every cycle.
- R2: With no loss held, each active-low enable equals the wanted level sampled on the previous clock edge. Want 0 gives enable 0 (drive low). Want 1 gives enable 1 (released).
- R3: A loss is detected only when all three hold: the block is releasing data, the synchronized clock reads 1, and the synchronized data reads 0. Any other combination, including data low while the clock is low, causes no loss. A steady input reaches `lost_o` after SYNC_STAGES+1 clock edges.
- R4: `lost_o` rises on the same edge on which both enables become 1.
- R5: At a loss, `lost_phase_o` takes the value of `phase_i`: 0 means address phase, 1 means data phase.
- R6: `retry_o` is 1 exactly when `lost_o` is 1 and `lost_phase_o` is 1. `slave_rx_o` is 1 exactly when `lost_o` is 1 and `lost_phase_o` is 0.
- R7: After a loss, both enables stay 1 whatever the wanted levels are, until a `start_i` pulse. From that pulse on, the enables follow the wanted levels again.
- R8: `lost_o` and `lost_phase_o` hold until a `clear_i` pulse. A later loss before the clear keeps the phase of the first loss.
- R9: While reset is asserted, both enables are 1 and `lost_o`, `lost_phase_o`, `retry_o` and `slave_rx_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | New-transfer pulse; ends the line release after a loss |
| clear_i | input | 1 | Software pulse; clears loss status |
| sda_want_i | input | 1 | Data level requested by the sequencer |
| scl_want_i | input | 1 | Clock level requested by the sequencer |
| phase_i | input | 1 | Current phase: 0 address, 1 data |
| sda_in_i | input | 1 | Sensed data line (asynchronous) |
| scl_in_i | input | 1 | Sensed clock line (asynchronous) |
| sda_oe_n_o | output | 1 | Data driver enable, active low |
| scl_oe_n_o | output | 1 | Clock driver enable, active low |
| sda_out_o | output | 1 | Data pad output value, always 0 |
| scl_out_o | output | 1 | Clock pad output value, always 0 |
| lost_o | output | 1 | Sticky arbitration-lost status |
| lost_phase_o | output | 1 | Phase of the recorded loss |
| retry_o | output | 1 | Data must be sent again |
| slave_rx_o | output | 1 | Slave receive should keep going |

## Verification
The hardest state to reach is a second loss while the first loss is still recorded. The lines must have been handed back by a start pulse while the status stays uncleared. Only then can the sticky phase be seen to ignore the new phase. The bench gets there with a loss in one phase, a start pulse alone, and a renewed mismatch with the other phase. A full sweep of every combination of wanted levels, sensed levels and phase separately covers the rule that only released data under a sensed-high clock can lose.

// File: rtl/od_arb_pkg.sv
package od_arb_pkg;
  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  localparam int unsigned LANES    = 2;
  localparam int unsigned LANE_SDA = 0;
  localparam int unsigned LANE_SCL = 1;
endpackage

// File: rtl/od_arb_sync.sv
module od_arb_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign stage_d[g] = async_i;
      end else begin : g_next
        assign stage_d[g] = stage_q[g-1];
      end
      // Reset to 1: a released line reads high.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '1;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign sync_o = stage_q[LAST];
endmodule

// File: rtl/od_arb_monitor.sv
module od_arb_monitor
  import od_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   clear_i,
  input  logic   phase_i,
  input  logic   sda_rel_i,
  input  logic   sda_s_i,
  input  logic   scl_s_i,
  output logic   release_o,
  output logic   lost_o,
  output phase_e phase_o
);
  logic   hold_q, hold_d;
  logic   lost_q, lost_d;
  phase_e phase_q, phase_d;
  logic   mismatch;
  logic   hold_en, lost_en;

  // Compare only while data is released and the clock is sensed high.
  always_comb begin
    mismatch = !hold_q && sda_rel_i && scl_s_i && !sda_s_i;
    hold_en  = mismatch || start_i;
    lost_en  = mismatch || clear_i;
    hold_d   = mismatch;
    lost_d   = mismatch;
    if (mismatch && (!lost_q || clear_i)) phase_d = phase_e'(phase_i);
    else if (clear_i)                     phase_d = PH_ADDR;
    else                                  phase_d = phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      lost_q  <= 1'b0;
      phase_q <= PH_ADDR;
    end else begin
      if (hold_en) hold_q <= hold_d;
      if (lost_en) lost_q <= lost_d;
      if (lost_en) phase_q <= phase_d;
    end
  end

  assign release_o = hold_en ? hold_d : hold_q;
  assign lost_o    = lost_q;
  assign phase_o   = phase_q;
endmodule

// File: rtl/od_arb_drive.sv
module od_arb_drive
  import od_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             release_i,
  input  logic [LANES-1:0] want_i,
  output logic [LANES-1:0] oe_n_o,
  output logic [LANES-1:0] out_o
);
  logic [LANES-1:0] oe_n_q, oe_n_d;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      always_comb oe_n_d[g] = release_i | want_i[g];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oe_n_q[g] <= 1'b1;
        else        oe_n_q[g] <= oe_n_d[g];
      end
      assign out_o[g] = 1'b0;
    end
  endgenerate

  assign oe_n_o = oe_n_q;
endmodule

// File: rtl/od_arb_driver.sv
module od_arb_driver
  import od_arb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic clear_i,
  input  logic sda_want_i,
  input  logic scl_want_i,
  input  logic phase_i,
  input  logic sda_in_i,
  input  logic scl_in_i,
  output logic sda_oe_n_o,
  output logic scl_oe_n_o,
  output logic sda_out_o,
  output logic scl_out_o,
  output logic lost_o,
  output logic lost_phase_o,
  output logic retry_o,
  output logic slave_rx_o
);
  logic             rst_q1, rst_q2;
  logic [LANES-1:0] sensed, sensed_s, want, oe_n, pad_out;
  logic             release_now;
  phase_e           phase_tag;

  // Reset asserts at once and releases two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  assign sensed[LANE_SDA] = sda_in_i;
  assign sensed[LANE_SCL] = scl_in_i;
  assign want[LANE_SDA]   = sda_want_i;
  assign want[LANE_SCL]   = scl_want_i;

  od_arb_sync #(.WIDTH(LANES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_q2),
    .async_i (sensed),
    .sync_o  (sensed_s)
  );

  od_arb_monitor u_mon (
    .clk       (clk),
    .rst_n     (rst_q2),
    .start_i   (start_i),
    .clear_i   (clear_i),
    .phase_i   (phase_i),
    .sda_rel_i (oe_n[LANE_SDA]),
    .sda_s_i   (sensed_s[LANE_SDA]),
    .scl_s_i   (sensed_s[LANE_SCL]),
    .release_o (release_now),
    .lost_o    (lost_o),
    .phase_o   (phase_tag)
  );

  od_arb_drive u_drv (
    .clk       (clk),
    .rst_n     (rst_q2),
    .release_i (release_now),
    .want_i    (want),
    .oe_n_o    (oe_n),
    .out_o     (pad_out)
  );

  assign sda_oe_n_o   = oe_n[LANE_SDA];
  assign scl_oe_n_o   = oe_n[LANE_SCL];
  assign sda_out_o    = pad_out[LANE_SDA];
  assign scl_out_o    = pad_out[LANE_SCL];
  assign lost_phase_o = phase_tag;
  assign retry_o      = lost_o && (phase_tag == PH_DATA);
  assign slave_rx_o   = lost_o && (phase_tag == PH_ADDR);
endmodule

// File: rtl/od_arb_driver_chk.sv
module od_arb_driver_chk (
  input logic clk,
  input logic rst_n,
  input logic clear_i,
  input logic sda_want_i,
  input logic sda_oe_n_o,
  input logic scl_oe_n_o,
  input logic lost_o,
  input logic lost_phase_o,
  input logic retry_o,
  input logic slave_rx_o
);
  assert_drive_low_intended_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sda_oe_n_o |-> !$past(sda_want_i));

  assert_loss_only_when_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_o) && !$past(lost_o) |-> $past(sda_oe_n_o));

  assert_release_on_loss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_o) |-> sda_oe_n_o && scl_oe_n_o);

  assert_retry_data_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retry_o |-> lost_o && lost_phase_o && !slave_rx_o);

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o && !clear_i |=> lost_o && $stable(lost_phase_o));
endmodule

bind od_arb_driver od_arb_driver_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clear_i      (clear_i),
  .sda_want_i   (sda_want_i),
  .sda_oe_n_o   (sda_oe_n_o),
  .scl_oe_n_o   (scl_oe_n_o),
  .lost_o       (lost_o),
  .lost_phase_o (lost_phase_o),
  .retry_o      (retry_o),
  .slave_rx_o   (slave_rx_o)
);

// File: tb/test_od_arb_driver.sv
module test_od_arb_driver;
  logic clk = 1'b0;
  logic rst_n;
  logic start_i, clear_i, sda_want_i, scl_want_i, phase_i, sda_in_i, scl_in_i;
  logic sda_oe_n_o, scl_oe_n_o, sda_out_o, scl_out_o;
  logic lost_o, lost_phase_o, retry_o, slave_rx_o;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always #4 clk = ~clk;

  od_arb_driver i_od_arb_driver (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .clear_i (clear_i),
    .sda_want_i (sda_want_i), .scl_want_i (scl_want_i), .phase_i (phase_i),
    .sda_in_i (sda_in_i), .scl_in_i (scl_in_i),
    .sda_oe_n_o (sda_oe_n_o), .scl_oe_n_o (scl_oe_n_o),
    .sda_out_o (sda_out_o), .scl_out_o (scl_out_o),
    .lost_o (lost_o), .lost_phase_o (lost_phase_o),
    .retry_o (retry_o), .slave_rx_o (slave_rx_o)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic safe();
    sda_want_i = 1; scl_want_i = 1; sda_in_i = 1; scl_in_i = 1;
    start_i = 0; clear_i = 0;
  endtask

  task automatic pulse(logic s, logic c);
    start_i = s; clear_i = c;
    cyc(1);
    start_i = 0; clear_i = 0;
  endtask

  // Checks the full output state against expected values.
  task automatic chk_all(string req, logic eoe_sda, logic eoe_scl, logic el, logic eph);
    chk(req, "sda_oe_n", sda_oe_n_o, eoe_sda);
    chk(req, "scl_oe_n", scl_oe_n_o, eoe_scl);
    chk(req, "lost", lost_o, el);
    chk(req, "phase", lost_phase_o, eph);
    chk("R6", "retry", retry_o, el & eph);
    chk("R6", "slave_rx", slave_rx_o, el & ~eph);
    chk("R1", "pad outs", sda_out_o | scl_out_o, 1'b0);
  endtask

  initial begin
    safe(); phase_i = 0; rst_n = 0;
    cyc(3);
    chk_all("R9", 1, 1, 0, 0);
    rst_n = 1;
    cyc(4);

    // R3 R2 R4 R5: sweep all combinations of wants, sensed levels and phase.
    for (int v = 0; v < 32; v++) begin
      logic sw, cw, si, ci, ph, loss;
      {sw, cw, si, ci, ph} = v[4:0];
      safe(); cyc(4); pulse(1, 1);
      sda_want_i = sw; scl_want_i = cw; sda_in_i = si; scl_in_i = ci; phase_i = ph;
      cyc(6);
      loss = sw & ci & ~si;
      chk_all("R3", loss | sw, loss | cw, loss, loss & ph);
      if (loss) begin
        // R7: a held release ignores wanted low levels.
        sda_want_i = 0; scl_want_i = 0;
        cyc(3);
        chk("R7", "sda held", sda_oe_n_o, 1'b1);
        chk("R7", "scl held", scl_oe_n_o, 1'b1);
      end
    end

    // R8 R7: start ends release but status sticks; a second loss keeps the first phase.
    safe(); cyc(4); pulse(1, 1);
    phase_i = 0; sda_in_i = 0;
    cyc(6);
    chk_all("R5", 1, 1, 1, 0);
    safe(); cyc(4); pulse(1, 0);
    sda_want_i = 0; scl_want_i = 0;
    cyc(2);
    chk_all("R7", 0, 0, 1, 0);
    sda_want_i = 1; scl_want_i = 1; phase_i = 1; sda_in_i = 0;
    cyc(6);
    chk_all("R8", 1, 1, 1, 0);
    safe(); cyc(4); pulse(0, 1);
    cyc(1);
    chk_all("R8", 1, 1, 0, 0);
    // A data-phase loss after clearing tags data.
    pulse(1, 0); phase_i = 1; sda_in_i = 0;
    cyc(6);
    chk_all("R6", 1, 1, 1, 1);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule